// File: doc/BRIEF.md
# Two-Wire Serial Clock Generator

This block derives the serial clock of a two-wire bus master from the system clock. A configuration word sets one prescaler exponent and two dividers, one for the low phase and one for the high phase. A build-time offset adds a fixed number of system cycles to every phase. For equal dividers the bus frequency is f_sys / (2 * (div * 2^exp + offset)).

Besides the clock level, the block gives the transfer sequencer two single-cycle strobes. One fires at the middle of each low phase, where the data line may change. The other fires at the middle of each high phase, where the data line is sampled. While the sequencer holds its run enable low, the clock rests high. When the enable is raised, the clock starts with a low phase of full length. A configuration written during a phase is picked up only at the next phase boundary.

Top module: `twi_clock_gen`

## Requirements
- R1: While reset is asserted, and on every cycle after a cycle edge at which runEn was sampled low, sclOut is 1 and both strobes are 0.
- R2: Field positions in cfgWord: low-phase divider in bits 7:0, high-phase divider in bits 15:8, prescaler exponent in bits 18:16.
- R3: A low phase lasts lowDiv*2^exp + OFFSET system cycles.
- R4: A high phase lasts highDiv*2^exp + OFFSET system cycles.
- R5: When runEn is first sampled high at a clock edge, sclOut is 0 from that edge on, and the first phase is a low phase of full length.
- R6: If runEn drops during a phase, sclOut goes high one edge later. A later enable starts a fresh low phase of full length.
- R7: An exponent above MAX_EXP is used as MAX_EXP, and both dividers are then taken as 255.
- R8: A change of cfgWord during a phase leaves the length of that phase unchanged. The next phase uses the new value.
- R9: changeStrobe is high for exactly one cycle per low phase, at cycle index floor(L/2), counted from 0 at the first low cycle of a phase of length L.
- R10: sampleStrobe is high for exactly one cycle per high phase, at cycle index floor(L/2) of that high phase.
- R11: changeStrobe is only ever high while sclOut is 0, sampleStrobe only while sclOut is 1, and never both together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable from the transfer sequencer |
| cfgWord | input | 2*DIV_W+EXP_W (19) | Exponent, high divider and low divider |
| sclOut | output | 1 | Serial clock level |
| changeStrobe | output | 1 | Mid-low pulse: data may change |
| sampleStrobe | output | 1 | Mid-high pulse: data is sampled |

## Verification
The assertions check on every cycle that the clock rests high after a disable, that the clock only falls while enabled, and that the strobes match the clock level, never overlap and never repeat on back-to-back cycles. Phase lengths, midpoint positions, the saturation of an oversized exponent and the deferred pickup of a new configuration depend on counts across many cycles. Only the bench's scenarios show these, by timing each phase at the ports.

// File: rtl/twi_clock_gen_pkg.sv
package twi_clock_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } phase_state_e;

  // control -> datapath
  typedef struct packed {
    logic load;     // latch a new phase length, restart count
    logic selHigh;  // length being loaded is for the high phase
    logic clear;    // hold the counter at zero (idle)
  } ctl_strobes_t;

  // datapath -> control
  typedef struct packed {
    logic phaseDone;
    logic atMid;
  } dp_status_t;

endpackage

// File: rtl/twi_clock_gen_dp.sv
module twi_clock_gen_dp
  import twi_clock_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 7,
  parameter int OFFSET  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_strobes_t             ctl,
  input  logic [2*DIV_W+EXP_W-1:0] cfgWord,
  output dp_status_t               status
);
  localparam int LEN_W = DIV_W + MAX_EXP + 2;
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic [EXP_W-1:0] expRaw, expEff;
  logic [DIV_W-1:0] divRaw, divEff;
  logic             overMax;
  logic [LEN_W-1:0] nextLen, phaseLen, elapsed;

  always_comb begin
    expRaw  = cfgWord[2*DIV_W +: EXP_W];
    divRaw  = ctl.selHigh ? cfgWord[DIV_W +: DIV_W] : cfgWord[0 +: DIV_W];
    overMax = expRaw > EXP_CAP;
    expEff  = overMax ? EXP_CAP : expRaw;
    divEff  = overMax ? {DIV_W{1'b1}} : divRaw;
    nextLen = (LEN_W'(divEff) << expEff) + LEN_W'(OFFSET);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseLen <= LEN_W'(OFFSET);
      elapsed  <= '0;
    end else if (ctl.load) begin
      phaseLen <= nextLen;
      elapsed  <= '0;
    end else if (ctl.clear) begin
      elapsed  <= '0;
    end else begin
      elapsed  <= elapsed + 1'b1;
    end
  end

  assign status.phaseDone = (elapsed == phaseLen - 1'b1);
  assign status.atMid     = (elapsed == (phaseLen >> 1));

endmodule

// File: rtl/twi_clock_gen_ctrl.sv
module twi_clock_gen_ctrl
  import twi_clock_gen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         runEn,
  input  dp_status_t   status,
  output ctl_strobes_t ctl,
  output logic         sclOut,
  output logic         changeStrobe,
  output logic         sampleStrobe
);
  phase_state_e state, stateNext;

  always_comb begin
    stateNext   = state;
    ctl.load    = 1'b0;
    ctl.selHigh = 1'b0;
    ctl.clear   = (state == ST_IDLE);
    if (!runEn) begin
      stateNext = ST_IDLE;
      ctl.clear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNext = ST_LOW;
          ctl.load  = 1'b1;
        end
        ST_LOW: if (status.phaseDone) begin
          stateNext   = ST_HIGH;
          ctl.load    = 1'b1;
          ctl.selHigh = 1'b1;
        end
        ST_HIGH: if (status.phaseDone) begin
          stateNext = ST_LOW;
          ctl.load  = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign sclOut       = (state != ST_LOW);
  assign changeStrobe = (state == ST_LOW)  && status.atMid;
  assign sampleStrobe = (state == ST_HIGH) && status.atMid;

endmodule

// File: rtl/twi_clock_gen.sv
module twi_clock_gen
  import twi_clock_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int MAX_EXP = 7,
  parameter int OFFSET  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     runEn,
  input  logic [2*DIV_W+EXP_W-1:0] cfgWord,
  output logic                     sclOut,
  output logic                     changeStrobe,
  output logic                     sampleStrobe
);
  ctl_strobes_t ctl;
  dp_status_t   status;

  twi_clock_gen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .status(status), .ctl(ctl),
    .sclOut(sclOut), .changeStrobe(changeStrobe), .sampleStrobe(sampleStrobe)
  );

  twi_clock_gen_dp #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .OFFSET(OFFSET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgWord(cfgWord), .status(status)
  );

endmodule

// File: rtl/twi_clock_gen_checker.sv
module twi_clock_gen_checker (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic sclOut,
  input logic changeStrobe,
  input logic sampleStrobe
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (sclOut && !changeStrobe && !sampleStrobe));

  assert_fall_needs_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> $past(runEn));

  assert_change_while_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    changeStrobe |-> !sclOut);

  assert_sample_while_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> sclOut);

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({changeStrobe, sampleStrobe}));

  assert_change_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    changeStrobe |=> !changeStrobe);

  assert_sample_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);
endmodule

bind twi_clock_gen twi_clock_gen_checker u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .sclOut(sclOut),
  .changeStrobe(changeStrobe), .sampleStrobe(sampleStrobe)
);

// File: tb/twi_clock_gen_bench.sv
module twi_clock_gen_bench;
  localparam int OFF  = 3;
  localparam int MAXE = 5;
  localparam int NVEC = 6;

  // {exp[18:16], highDiv[15:8], lowDiv[7:0]}, expected low / high lengths
  localparam logic [18:0] VEC_CFG [NVEC] = '{
    {3'd0, 8'd2, 8'd2}, {3'd1, 8'd3, 8'd5}, {3'd2, 8'd1, 8'd0},
    {3'd3, 8'd4, 8'd10}, {3'd5, 8'd2, 8'd1}, {3'd4, 8'd0, 8'd7}};
  localparam int VEC_LOW  [NVEC] = '{5, 13, 3, 83, 35, 115};
  localparam int VEC_HIGH [NVEC] = '{5, 9, 7, 35, 67, 3};

  logic clk = 0, rstN = 0, runEn = 0;
  logic [18:0] cfgWord = '0;
  logic sclOut, changeStrobe, sampleStrobe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twi_clock_gen #(.DIV_W(8), .EXP_W(3), .MAX_EXP(MAXE), .OFFSET(OFF)) u_twi_clock_gen (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWord(cfgWord),
    .sclOut(sclOut), .changeStrobe(changeStrobe), .sampleStrobe(sampleStrobe));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int changeIdx, input logic [18:0] newCfg,
                         output int lowLen, output int highLen,
                         output int chgPos, output int chgCnt,
                         output int smpPos, output int smpCnt, output int badCnt);
    int guard = 0;
    lowLen = 0; highLen = 0; chgPos = -1; chgCnt = 0;
    smpPos = -1; smpCnt = 0; badCnt = 0;
    while (sclOut !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    while (sclOut === 1'b0 && lowLen < 20000) begin
      if (lowLen == changeIdx) cfgWord = newCfg;
      if (changeStrobe) begin chgPos = lowLen; chgCnt++; end
      if (sampleStrobe) badCnt++;
      lowLen++;
      @(negedge clk);
    end
    while (sclOut === 1'b1 && highLen < 20000) begin
      if (sampleStrobe) begin smpPos = highLen; smpCnt++; end
      if (changeStrobe) badCnt++;
      highLen++;
      @(negedge clk);
    end
  endtask

  task automatic startRun(input logic [18:0] cfg);
    runEn = 0;
    repeat (2) @(negedge clk);
    cfgWord = cfg;
    runEn = 1;
    @(negedge clk);
    check("R5 scl low one edge after enable", sclOut, 0);
  endtask

  initial begin
    int lo, hi, cp, cc, sp, sc, bad;
    repeat (3) @(negedge clk);
    check("R1 reset scl", sclOut, 1);
    check("R1 reset strobes", {changeStrobe, sampleStrobe}, 0);
    rstN = 1;
    repeat (5) @(negedge clk);
    check("R1 idle scl", sclOut, 1);

    for (int i = 0; i < NVEC; i++) begin
      startRun(VEC_CFG[i]);
      measure(-1, '0, lo, hi, cp, cc, sp, sc, bad);
      check("R3 R2 low length", lo, VEC_LOW[i]);
      check("R4 R2 high length", hi, VEC_HIGH[i]);
      check("R9 change position", cp, VEC_LOW[i] / 2);
      check("R9 change count", cc, 1);
      check("R10 sample position", sp, VEC_HIGH[i] / 2);
      check("R10 sample count", sc, 1);
      check("R11 wrong-level strobes", bad, 0);
    end

    // R7: exponent 6 exceeds MAXE=5 -> dividers 255, exponent 5
    startRun({3'd6, 8'd2, 8'd1});
    measure(-1, '0, lo, hi, cp, cc, sp, sc, bad);
    check("R7 clamped low length", lo, 255 * 32 + OFF);
    check("R7 clamped high length", hi, 255 * 32 + OFF);

    // R8: new word written in mid low phase; low keeps old, high uses new
    startRun({3'd0, 8'd2, 8'd2});
    measure(2, {3'd1, 8'd3, 8'd5}, lo, hi, cp, cc, sp, sc, bad);
    check("R8 low keeps old length", lo, 5);
    check("R8 high takes new length", hi, 9);

    // R6: drop enable in mid low phase, then restart
    startRun({3'd2, 8'd3, 8'd4});
    repeat (4) @(negedge clk);
    runEn = 0;
    @(negedge clk);
    check("R6 scl high one edge after disable", sclOut, 1);
    repeat (30) begin
      @(negedge clk);
      if (sclOut !== 1'b1 || changeStrobe || sampleStrobe)
        check("R1 idle stays high", 0, 1);
    end
    check("R1 idle after disable", {sclOut, changeStrobe, sampleStrobe}, 3'b100);
    runEn = 1;
    measure(-1, '0, lo, hi, cp, cc, sp, sc, bad);
    check("R6 restart full low length", lo, 4 * 4 + OFF);
    check("R6 restart high length", hi, 3 * 4 + OFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule